// File: doc/BRIEF.md
# Push-Pull Two-Wire Bus Master

This block is the master end of a point-to-point serial link. It drives a clock line and a data line, both push-pull, to a single slave. Each transaction opens with a start condition and sends a register address. It then either sends up to eight data bytes or reads up to eight back within the same transaction. Every byte on the wire, the address included, is followed by one even-parity bit. There is no slave address and no acknowledge slot.

A transfer is launched with a one-cycle start strobe. The direction, byte count, register address, write bytes, clock divider and data-line delay are captured on that cycle. The block raises busy until the stop condition has been sent, then pulses done for one cycle. If a received parity bit is wrong, the read is cut short, the error flag is set and the index of the bad byte is reported. Read bytes appear on a packed output, with byte k in bits 8k+7..8k.

Top module: `ppwire_master`

## Requirements
- R1: After reset, and whenever busy is low, sclOut=1, sdaOut=1 and sdaOe=1. After reset, busy, done and error are 0 and rdData is 0.
- R2: A transaction begins with sdaOut falling while sclOut is high, and ends with sdaOut rising while sclOut is high. On the clock edge of that final rise, done pulses high for exactly one cycle and busy drops.
- R3: The wire carries the address byte and then the data bytes, each sent MSB first as 8 data bits plus 1 parity bit, with no acknowledge slot. A completed transfer of N bytes therefore shows 9*(N+1) SCL high pulses plus one for the stop. SDA does not change while SCL is high except at start and stop.
- R4: Each parity bit equals the XOR of the 8 bits before it (even parity).
- R5: When readNotWrite=1, the master releases SDA (sdaOe=0) for all 9 bits of every data byte, including its parity bit, and samples sdaIn on each SCL rise. It drives the address bits itself. Received byte k goes to rdData[8k+7:8k]. Bytes that were not received read 0, and a write leaves rdData at 0.
- R6: byteCount selects 1 to 8 data bytes. A value of 0 is treated as 1, and values above 8 are treated as 8.
- R7: Each SCL half-period lasts clkDiv+1 system cycles, so consecutive SCL rises are 2*(clkDiv+1) cycles apart (clkDiv >= 1).
- R8: A driven SDA change happens d+1 cycles after SCL falls, where d = min(sdaDelay, clkDiv-1).
- R9: On a read, a parity mismatch in data byte k ends the transfer with a stop right after that byte's parity bit. error goes to 1 and errIndex to k, and byte k and all later bytes are not stored.
- R10: A start strobe while busy is ignored. error and errIndex hold their values until the next accepted start, which clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | One-cycle strobe that launches a transfer |
| readNotWrite | input | 1 | 1 = read data bytes, 0 = write them |
| byteCount | input | 4 | Number of data bytes (1 to 8) |
| regAddr | input | 8 | Register address sent first |
| wrData | input | 64 | Write bytes, byte k in bits 8k+7..8k |
| clkDiv | input | 8 | SCL half-period minus one, in system cycles |
| sdaDelay | input | 3 | Delay of SDA changes after SCL falls |
| sdaIn | input | 1 | Data line as seen at the pad |
| sclOut | output | 1 | Clock line |
| sdaOut | output | 1 | Data line drive value |
| sdaOe | output | 1 | Data line drive enable |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| error | output | 1 | Received parity mismatch |
| errIndex | output | 3 | Index of the failing data byte |
| rdData | output | 64 | Received bytes, byte k in bits 8k+7..8k |

## Verification
The bench uses a slave model that corrupts the parity of a chosen byte. A design that skipped the check, or that stored the bad byte, would report the wrong errIndex or non-zero upper bytes, and would show the wrong number of SCL pulses before the stop. It runs byte counts of 0 and 12, which catch clamping that is missing or off by one. It programs an SDA delay larger than the clock divider, which exposes a design that moves SDA at the same moment as SCL. A second start strobe in mid-transfer with a different address must leave the captured bit stream and the done count unchanged.

// File: rtl/ppwire_pkg.sv
package ppwire_pkg;
  localparam int BYTE_W    = 8;
  localparam int MAX_BYTES = 8;
  localparam int CNT_W     = $clog2(MAX_BYTES + 1);
  localparam int IDX_W     = $clog2(MAX_BYTES);
  localparam int BIT_W     = $clog2(BYTE_W + 1);
  localparam int DATA_W    = BYTE_W * MAX_BYTES;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_LOW, ST_HIGH, ST_STOPLOW, ST_STOPHIGH
  } ctrlState_e;

  typedef struct packed {
    logic             latch;
    logic             sdaLow;
    logic             sdaHigh;
    logic             drive;
    logic             rxPhase;
    logic             sample;
    logic             store;
    logic [BIT_W-1:0] bitIdx;
    logic [CNT_W-1:0] phase;
  } ctrlStrobe_t;
endpackage

// File: rtl/ppwire_ctrl.sv
module ppwire_ctrl
  import ppwire_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             readNotWrite,
  input  logic [CNT_W-1:0] byteCount,
  input  logic [DIV_W-1:0] clkDiv,
  input  logic [DLY_W-1:0] sdaDelay,
  input  logic             parityBad,
  output ctrlStrobe_t      stb,
  output logic             sclOut,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic [IDX_W-1:0] errIndex
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(BYTE_W);

  ctrlState_e       state;
  logic [DIV_W-1:0] halfCnt, divR, effDly, dlyExt;
  logic [DLY_W-1:0] dlyR;
  logic [BIT_W-1:0] bitIdx;
  logic [CNT_W-1:0] phase, lastPhase, cntEff;
  logic             isRead, halfEnd, rxPhase;

  assign halfEnd = (halfCnt == divR);
  assign dlyExt  = DIV_W'(dlyR);
  assign effDly  = (dlyExt >= divR) ? ((divR == '0) ? '0 : divR - DIV_W'(1)) : dlyExt;
  assign rxPhase = isRead && (phase != '0);
  assign busy    = (state != ST_IDLE);
  assign cntEff  = (byteCount == '0) ? CNT_W'(1) :
                   (byteCount > CNT_W'(MAX_BYTES)) ? CNT_W'(MAX_BYTES) : byteCount;

  always_comb begin
    stb         = '0;
    stb.bitIdx  = bitIdx;
    stb.phase   = phase;
    stb.rxPhase = rxPhase;
    stb.latch   = (state == ST_IDLE) && startReq;
    stb.sdaLow  = ((state == ST_IDLE) && startReq) ||
                  ((state == ST_STOPLOW) && (halfCnt == effDly));
    stb.sdaHigh = (state == ST_STOPHIGH) && halfEnd;
    stb.drive   = (state == ST_LOW) && (halfCnt == effDly);
    stb.sample  = (state == ST_LOW) && halfEnd && rxPhase;
    stb.store   = (state == ST_HIGH) && halfEnd && (bitIdx == LAST_BIT) &&
                  rxPhase && !parityBad;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      halfCnt   <= '0;
      divR      <= '0;
      dlyR      <= '0;
      bitIdx    <= '0;
      phase     <= '0;
      lastPhase <= '0;
      isRead    <= 1'b0;
      sclOut    <= 1'b1;
      done      <= 1'b0;
      error     <= 1'b0;
      errIndex  <= '0;
    end else begin
      done    <= 1'b0;
      halfCnt <= halfCnt + DIV_W'(1);
      unique case (state)
        ST_IDLE: begin
          halfCnt <= '0;
          if (startReq) begin
            state     <= ST_START;
            divR      <= clkDiv;
            dlyR      <= sdaDelay;
            isRead    <= readNotWrite;
            lastPhase <= cntEff;
            error     <= 1'b0;
            errIndex  <= '0;
          end
        end
        ST_START: if (halfEnd) begin
          state   <= ST_LOW;
          halfCnt <= '0;
          sclOut  <= 1'b0;
          bitIdx  <= '0;
          phase   <= '0;
        end
        ST_LOW: if (halfEnd) begin
          state   <= ST_HIGH;
          halfCnt <= '0;
          sclOut  <= 1'b1;
        end
        ST_HIGH: if (halfEnd) begin
          halfCnt <= '0;
          sclOut  <= 1'b0;
          if (bitIdx != LAST_BIT) begin
            bitIdx <= bitIdx + BIT_W'(1);
            state  <= ST_LOW;
          end else if (rxPhase && parityBad) begin
            error    <= 1'b1;
            errIndex <= IDX_W'(phase - CNT_W'(1));
            state    <= ST_STOPLOW;
          end else if (phase == lastPhase) begin
            state <= ST_STOPLOW;
          end else begin
            phase  <= phase + CNT_W'(1);
            bitIdx <= '0;
            state  <= ST_LOW;
          end
        end
        ST_STOPLOW: if (halfEnd) begin
          state   <= ST_STOPHIGH;
          halfCnt <= '0;
          sclOut  <= 1'b1;
        end
        ST_STOPHIGH: if (halfEnd) begin
          state   <= ST_IDLE;
          halfCnt <= '0;
          done    <= 1'b1;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);

  // R9
  err_index_chk: assert property (@(posedge clk) disable iff (!rstN)
    (error && busy) |-> ({1'b0, errIndex} < lastPhase));

  // R7
  half_len_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) != ST_IDLE && !$past(halfEnd)) |-> $stable(sclOut));
endmodule

// File: rtl/ppwire_dpath.sv
module ppwire_dpath
  import ppwire_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       stb,
  input  logic [BYTE_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              sdaIn,
  output logic              sdaOut,
  output logic              sdaOe,
  output logic              parityBad,
  output logic [DATA_W-1:0] rdData
);
  logic [BYTE_W-1:0] addrR;
  logic [BYTE_W-1:0] wrBuf [MAX_BYTES];
  logic [BYTE_W-1:0] rdBuf [MAX_BYTES];
  logic [BYTE_W:0]   rxShift;
  logic [BYTE_W-1:0] txByte;
  logic [IDX_W-1:0]  selIdx;
  logic              txBit;

  assign selIdx    = IDX_W'(stb.phase - CNT_W'(1));
  assign txByte    = (stb.phase == '0) ? addrR : wrBuf[selIdx];
  assign txBit     = (stb.bitIdx == BIT_W'(BYTE_W)) ? ^txByte :
                     txByte[IDX_W'(BIT_W'(BYTE_W - 1) - stb.bitIdx)];
  assign parityBad = ^rxShift;

  for (genvar g = 0; g < MAX_BYTES; g++) begin : g_rd
    assign rdData[g*BYTE_W +: BYTE_W] = rdBuf[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrR   <= '0;
      sdaOut  <= 1'b1;
      sdaOe   <= 1'b1;
      rxShift <= '0;
      for (int i = 0; i < MAX_BYTES; i++) begin
        wrBuf[i] <= '0;
        rdBuf[i] <= '0;
      end
    end else begin
      if (stb.latch) begin
        addrR <= regAddr;
        for (int i = 0; i < MAX_BYTES; i++) begin
          wrBuf[i] <= wrData[i*BYTE_W +: BYTE_W];
          rdBuf[i] <= '0;
        end
      end
      if (stb.sdaLow) begin
        sdaOut <= 1'b0;
        sdaOe  <= 1'b1;
      end
      if (stb.sdaHigh) begin
        sdaOut <= 1'b1;
        sdaOe  <= 1'b1;
      end
      if (stb.drive) begin
        sdaOe <= !stb.rxPhase;
        if (!stb.rxPhase) sdaOut <= txBit;
      end
      if (stb.sample) rxShift <= {rxShift[BYTE_W-1:0], sdaIn};
      if (stb.store)  rdBuf[selIdx] <= rxShift[BYTE_W:1];
    end
  end

  // R5
  rx_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.drive && stb.rxPhase) |=> !sdaOe);
endmodule

// File: rtl/ppwire_master.sv
module ppwire_master
  import ppwire_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int DLY_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              readNotWrite,
  input  logic [CNT_W-1:0]  byteCount,
  input  logic [BYTE_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DIV_W-1:0]  clkDiv,
  input  logic [DLY_W-1:0]  sdaDelay,
  input  logic              sdaIn,
  output logic              sclOut,
  output logic              sdaOut,
  output logic              sdaOe,
  output logic              busy,
  output logic              done,
  output logic              error,
  output logic [IDX_W-1:0]  errIndex,
  output logic [DATA_W-1:0] rdData
);
  ctrlStrobe_t stb;
  logic        parityBad;

  ppwire_ctrl #(.DIV_W(DIV_W), .DLY_W(DLY_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .readNotWrite(readNotWrite),
    .byteCount(byteCount), .clkDiv(clkDiv), .sdaDelay(sdaDelay),
    .parityBad(parityBad), .stb(stb), .sclOut(sclOut), .busy(busy),
    .done(done), .error(error), .errIndex(errIndex)
  );

  ppwire_dpath u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .regAddr(regAddr), .wrData(wrData),
    .sdaIn(sdaIn), .sdaOut(sdaOut), .sdaOe(sdaOe), .parityBad(parityBad),
    .rdData(rdData)
  );

  // R1
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (sclOut && sdaOut && sdaOe));

  // R3
  sda_stable_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclOut && $past(sclOut) && busy && $past(busy)) |-> $stable(sdaOut));
endmodule

// File: tb/ppwire_master_tb.sv
module ppwire_master_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startReq = 1'b0, readNotWrite = 1'b0, sdaIn = 1'b1;
  logic [3:0]  byteCount = 4'd1;
  logic [7:0]  regAddr = '0, clkDiv = 8'd3;
  logic [63:0] wrData = '0;
  logic [2:0]  sdaDelay = '0;
  logic        sclOut, sdaOut, sdaOe, busy, done, error;
  logic [2:0]  errIndex;
  logic [63:0] rdData;

  always #2 clk = ~clk;

  ppwire_master u_dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .readNotWrite(readNotWrite),
    .byteCount(byteCount), .regAddr(regAddr), .wrData(wrData), .clkDiv(clkDiv),
    .sdaDelay(sdaDelay), .sdaIn(sdaIn), .sclOut(sclOut), .sdaOut(sdaOut),
    .sdaOe(sdaOe), .busy(busy), .done(done), .error(error), .errIndex(errIndex),
    .rdData(rdData)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // slave model and line monitor
  bit        rdMode = 0;
  int        nBytes = 1;
  logic [63:0] slaveData = '0;
  logic [7:0]  corrupt = '0;
  int        riseCount = 0, startSeen = 0, stopSeen = 0, doneCnt = 0;
  int        periodBad = 0, delayBad = 0, delayCnt = 0, expPeriod = 8, expDelay = 1;
  int        cyc = 0, lastRise = -1, sinceFall = 0;
  logic      capBits [96];
  logic      capOe [96];
  logic      prevScl = 1'b1, prevSda = 1'b1, prevOe = 1'b1;

  function automatic logic slaveBit(input int k);
    int j, p;
    logic [7:0] b;
    if (!rdMode || k < 9) return 1'b1;
    j = (k - 9) / 9;
    p = (k - 9) % 9;
    if (j >= nBytes) return 1'b1;
    b = slaveData[8*j +: 8];
    if (p < 8) return b[7-p];
    return (^b) ^ corrupt[j];
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (done) doneCnt++;
    if (sclOut && !prevScl) begin
      if (riseCount < 96) begin
        capBits[riseCount] = sdaOut;
        capOe[riseCount] = sdaOe;
      end
      if (lastRise >= 0 && (cyc - lastRise) != expPeriod) periodBad++;
      lastRise = cyc;
      riseCount++;
    end
    if (!sclOut && prevScl) begin
      sinceFall = 0;
      sdaIn = slaveBit(riseCount);
    end else sinceFall++;
    if (sclOut && prevScl && sdaOe && prevOe) begin
      if (prevSda && !sdaOut) startSeen++;
      if (!prevSda && sdaOut) stopSeen++;
    end
    if (!sclOut && sdaOe && prevOe && (sdaOut != prevSda)) begin
      delayCnt++;
      if (sinceFall != expDelay) delayBad++;
    end
    prevScl = sclOut;
    prevSda = sdaOut;
    prevOe = sdaOe;
  end

  task automatic launch(input bit rd, input logic [3:0] cnt, input logic [7:0] addr,
                        input logic [7:0] div, input logic [2:0] dly,
                        input logic [63:0] data, input logic [7:0] bad8);
    int eff;
    @(negedge clk);
    rdMode = rd;
    nBytes = (cnt == 0) ? 1 : (cnt > 8) ? 8 : int'(cnt);
    slaveData = data;
    corrupt = bad8;
    eff = (dly >= div) ? ((div == 0) ? 0 : int'(div) - 1) : int'(dly);
    expDelay = eff + 1;
    expPeriod = 2 * (int'(div) + 1);
    riseCount = 0; startSeen = 0; stopSeen = 0; doneCnt = 0;
    periodBad = 0; delayBad = 0; delayCnt = 0; lastRise = -1;
    readNotWrite = rd; byteCount = cnt; regAddr = addr; clkDiv = div;
    sdaDelay = dly; wrData = data; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic waitDone();
    int t = 0;
    while (!done && t < 20000) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  function automatic logic [7:0] phaseByte(input logic [7:0] addr, input logic [63:0] data, input int p);
    return (p == 0) ? addr : data[8*(p-1) +: 8];
  endfunction

  task automatic verifyStream(input bit rd, input int n, input logic [7:0] addr, input logic [63:0] data);
    int dataErr = 0, parErr = 0, oeErr = 0;
    for (int p = 0; p <= n; p++) begin
      logic [7:0] b;
      b = phaseByte(addr, data, p);
      for (int k = 0; k < 9; k++)
        if (capOe[9*p+k] !== ((p == 0) ? 1'b1 : !rd)) oeErr++;
      if (rd && p > 0) continue;
      for (int k = 0; k < 8; k++) if (capBits[9*p+k] !== b[7-k]) dataErr++;
      if (capBits[9*p+8] !== ^b) parErr++;
    end
    check(dataErr == 0, "R3 data bits MSB first", 64'(dataErr), 0);
    check(parErr == 0, "R4 even parity bits", 64'(parErr), 0);
    check(oeErr == 0, "R5 sda release on read data", 64'(oeErr), 0);
  endtask

  typedef struct packed {
    logic rd; logic [3:0] cnt; logic [7:0] addr; logic [7:0] div; logic [2:0] dly; logic [63:0] data;
  } vec_t;

  localparam vec_t VECS [5] = '{
    '{1'b0, 4'd1, 8'h3A, 8'd3, 3'd1, 64'h00000000000000A5},
    '{1'b0, 4'd3, 8'hC1, 8'd5, 3'd2, 64'h000000000081FF55},
    '{1'b1, 4'd2, 8'h12, 8'd2, 3'd0, 64'h0000000000006C93},
    '{1'b1, 4'd8, 8'hFE, 8'd4, 3'd7, 64'h0123456789ABCDEF},
    '{1'b0, 4'd8, 8'h00, 8'd1, 3'd0, 64'hFEDCBA9876543210}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(sclOut && sdaOut && sdaOe && !busy && !done && !error && rdData == 0,
          "R1 reset state", {58'b0, sclOut, sdaOut, sdaOe, busy, done, error}, 64'h38);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    foreach (VECS[i]) begin
      vec_t v;
      logic [63:0] expRd;
      int n;
      v = VECS[i];
      n = int'(v.cnt);
      launch(v.rd, v.cnt, v.addr, v.div, v.dly, v.data, 8'h00);
      waitDone();
      expRd = '0;
      if (v.rd) for (int k = 0; k < n; k++) expRd[8*k +: 8] = v.data[8*k +: 8];
      check(startSeen == 1 && stopSeen == 1 && doneCnt == 1 && !busy,
            "R2 start stop done", 64'(startSeen*100 + stopSeen*10 + doneCnt), 64'd111);
      check(riseCount == 9*(n+1)+1, "R3 scl pulse count", 64'(riseCount), 64'(9*(n+1)+1));
      verifyStream(v.rd, n, v.addr, v.data);
      check(rdData == expRd && !error, "R5 read data", rdData, expRd);
      check(periodBad == 0, "R7 scl period", 64'(periodBad), 0);
      check(delayCnt > 0 && delayBad == 0, "R8 sda delay", 64'(delayBad), 0);
      check(sclOut && sdaOut && sdaOe, "R1 idle lines after transfer",
            {61'b0, sclOut, sdaOut, sdaOe}, 64'h7);
    end

    // R6 count 0 clamps to 1
    launch(1'b0, 4'd0, 8'h96, 8'd2, 3'd1, 64'h00000000000000C3, 8'h00);
    waitDone();
    check(riseCount == 19, "R6 count zero as one", 64'(riseCount), 64'd19);
    // R6 count 12 clamps to 8
    launch(1'b0, 4'd12, 8'h69, 8'd1, 3'd0, 64'h1122334455667788, 8'h00);
    waitDone();
    check(riseCount == 82, "R6 count above max as eight", 64'(riseCount), 64'd82);
    verifyStream(1'b0, 8, 8'h69, 64'h1122334455667788);

    // R9 parity error in data byte 2
    launch(1'b1, 4'd4, 8'h47, 8'd3, 3'd1, 64'h00000000D4E5F607, 8'h04);
    waitDone();
    check(error == 1'b1 && errIndex == 3'd2, "R9 error and index", {60'b0, error, errIndex}, 64'hA);
    check(rdData == 64'h000000000000F607, "R9 bytes after fault not stored", rdData, 64'hF607);
    check(riseCount == 37 && stopSeen == 1, "R9 early stop", 64'(riseCount), 64'd37);
    repeat (20) @(negedge clk);
    check(error == 1'b1 && errIndex == 3'd2, "R10 error held", {60'b0, error, errIndex}, 64'hA);

    // R10 start while busy ignored; accepted start clears error
    launch(1'b0, 4'd1, 8'h5C, 8'd3, 3'd1, 64'h000000000000005A, 8'h00);
    check(error == 1'b0, "R10 start clears error", 64'(error), 0);
    repeat (40) @(negedge clk);
    regAddr = 8'h33; wrData = 64'hFF; byteCount = 4'd5; startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    waitDone();
    check(riseCount == 19 && startSeen == 1 && doneCnt == 1, "R10 busy start ignored",
          64'(riseCount), 64'd19);
    verifyStream(1'b0, 1, 8'h5C, 64'h5A);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule